// File: doc/BRIEF.md
# Memory Test Access Port with Output Tri-State Override

This block is the boundary-scan test port of a memory device. It contains the sixteen-state test controller, a three-bit instruction register, a one-bit bypass path, a 32-bit identification register and a boundary register of configurable length. All of them are clocked by the test clock `tck`. Serial data enters on `tdi` and leaves on `tdo`. Pad electronics and the assignment of pins to cells are outside the block. The pin values reach it as one parallel vector, and the boundary update stage leaves it as another.

Two of the boundary instructions also raise `out_hiz`. The memory's data output drivers use this signal to go to high impedance. Under test control the block never carries array contents to `tdo`. There is no asynchronous test reset. The controller is reset by the chip's power-up reset `rst`, or by holding `tms` high. The pads are expected to pull undriven `tms` and `tdi` to logic 1.

Top module: `scan_port`

## Requirements
- R1: After `rst` the controller is in Test-Logic-Reset, the instruction is IDCODE (001), `tdo_oe` and `out_hiz` are 0, and a data scan returns the identification value.
- R2: The controller follows the standard sixteen-state graph on `tms` at the rising edge of `tck`. Five consecutive cycles with `tms`=1 reach Test-Logic-Reset from any state, and that state reloads IDCODE and clears `out_hiz`.
- R3: In Capture-IR the instruction shift stage loads 001. An instruction scan therefore shifts out 1, then 0, then 0, least significant bit first. `tdi` enters at bit 2.
- R4: Opcodes take effect in Update-IR. 000 (external test) and 010 (sample with tri-state) select the boundary register and set `out_hiz`=1. 100 (sample) selects the boundary register with `out_hiz`=0. 001 selects the identification register. 111 and the reserved codes 011, 101 and 110 select the one-bit bypass path.
- R5: The identification value is laid out as follows, and it is shifted out bit 0 first. Bits 31:29 hold the revision. Bits 28:12 hold the configuration {00, density[2:0], 0, width[1:0], 0, 0, 0, quad, 0, burst4, 0, separate-io, 0}. Bits 11:1 hold the manufacturer code. Bit 0 is 1.
- R6: The bypass path captures 0 in Capture-DR. The first bit shifted out is therefore 0, and every later bit is `tdi` delayed by one cycle.
- R7: With the boundary register selected, Capture-DR loads `pins_i` into the cells. Shift-DR then moves the cells towards cell 0, which drives `tdo`, and `tdi` enters cell BSR_LEN-1.
- R8: Update-DR copies the boundary cells to `cells_o` only while a boundary instruction is active. Under any other instruction `cells_o` keeps its value.
- R9: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only in Shift-DR and Shift-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| tms | input | 1 | Test mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| pins_i | input | BSR_LEN | Parallel pin values captured by the boundary cells |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_oe | output | 1 | Output enable for `tdo`; low means high impedance |
| out_hiz | output | 1 | Forces the memory data outputs to high impedance |
| cells_o | output | BSR_LEN | Boundary update stage |

## Verification
The scan paths are tried with several serial patterns. Alternating and irregular bit patterns through bypass and the reserved codes show that the path is one bit long and that its first bit is a captured 0. Shifting through the identification register, both right after reset and after an explicit IDCODE load, tells a correct field layout apart from a reordered one. Two different pin vectors are used: one is captured under sample and external test, and the other is shifted in and updated, which separates the capture path from the update path. The same boundary shift is then repeated under bypass to show that `cells_o` holds. A run of five `tms` ones from deep inside Shift-DR shows that the controller falls back to IDCODE with the tri-state override released.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [3:0] {
    ST_TLR, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
  } tap_st_e;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;

  localparam int IR_W = 3;
  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic dr_sel_e op_decode(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPZ, OP_SAMPLE: op_decode = SEL_BSR;
      OP_IDCODE:                      op_decode = SEL_ID;
      default:                        op_decode = SEL_BYP;
    endcase
  endfunction

  function automatic logic op_forces_hiz(input logic [IR_W-1:0] op);
    op_forces_hiz = (op == OP_EXTEST) || (op == OP_SAMPZ);
  endfunction
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import scan_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tms,
  output tap_st_e st
);
  tap_st_e nxt;

  always_comb begin
    case (st)
      ST_TLR:    nxt = tms ? ST_TLR    : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
      ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
      ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_TLR;
    else     st <= nxt;
  end

  AST_TMS_FIVE_RESET: assert property (@(posedge clk) disable iff (rst)
    (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> (st == ST_TLR)); // R2
endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            tdi,
  input  tap_st_e         st,
  output logic            ir_lsb,
  output dr_sel_e         sel,
  output logic            hiz
);
  logic [IR_W-1:0] sh_q;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= IR_CAPTURE;
    end else if (st == ST_CAP_IR) begin
      sh_q <= IR_CAPTURE;
    end else if (st == ST_SH_IR) begin
      sh_q <= {tdi, sh_q[IR_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || st == ST_TLR) begin
      ir_q <= OP_IDCODE;
      hiz  <= 1'b0;
    end else if (st == ST_UPD_IR) begin
      ir_q <= sh_q;
      hiz  <= op_forces_hiz(sh_q);
    end
  end

  assign ir_lsb = sh_q[0];
  assign sel    = op_decode(ir_q);

  AST_IR_TLR_IDCODE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TLR) |=> (ir_q == OP_IDCODE && !hiz)); // R1
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st != ST_UPD_IR && st != ST_TLR) |=> $stable(ir_q)); // R4
  AST_HIZ_OPCODE: assert property (@(posedge clk) disable iff (rst)
    hiz |-> (ir_q == OP_EXTEST || ir_q == OP_SAMPZ)); // R4
endmodule

// File: rtl/scan_dr.sv
module scan_dr
  import scan_pkg::*;
#(
  parameter int          BSR_LEN = 107,
  parameter logic [31:0] ID_VAL  = 32'h0000_0001
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               tdi,
  input  tap_st_e            st,
  input  dr_sel_e            sel,
  input  logic [BSR_LEN-1:0] pins_i,
  output logic               dr_lsb,
  output logic [BSR_LEN-1:0] cells_o
);
  localparam int ID_W = 32;

  logic               byp_q;
  logic [ID_W-1:0]    id_q;
  logic [BSR_LEN-1:0] bsr_q;
  logic [BSR_LEN:0]   chain;
  logic               cap, shf;

  assign cap   = (st == ST_CAP_DR);
  assign shf   = (st == ST_SH_DR);
  assign chain = {tdi, bsr_q};

  always_ff @(posedge clk) begin
    if (rst || cap)                 byp_q <= 1'b0;
    else if (shf && sel == SEL_BYP) byp_q <= tdi;
  end

  always_ff @(posedge clk) begin
    if (rst)                       id_q <= ID_VAL;
    else if (cap && sel == SEL_ID) id_q <= ID_VAL;
    else if (shf && sel == SEL_ID) id_q <= {tdi, id_q[ID_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst)                        bsr_q <= '0;
    else if (cap && sel == SEL_BSR) bsr_q <= pins_i;
    else if (shf && sel == SEL_BSR) bsr_q <= chain[BSR_LEN:1];
  end

  always_ff @(posedge clk) begin
    if (rst)                                   cells_o <= '0;
    else if (st == ST_UPD_DR && sel == SEL_BSR) cells_o <= bsr_q;
  end

  always_comb begin
    case (sel)
      SEL_ID:  dr_lsb = id_q[0];
      SEL_BSR: dr_lsb = bsr_q[0];
      default: dr_lsb = byp_q;
    endcase
  end

  AST_BYP_CAPTURE_ZERO: assert property (@(posedge clk) disable iff (rst)
    cap |=> !byp_q); // R6
  AST_CELLS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(st == ST_UPD_DR && sel == SEL_BSR) |=> $stable(cells_o)); // R8
endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_pkg::*;
#(
  parameter int          BSR_LEN    = 107,
  parameter logic [2:0]  ID_REV     = 3'd0,
  parameter logic [2:0]  ID_DENSITY = 3'b001,
  parameter logic [1:0]  ID_WIDTH   = 2'b11,
  parameter logic        ID_QUAD    = 1'b1,
  parameter logic        ID_BURST4  = 1'b0,
  parameter logic        ID_SEP_IO  = 1'b1,
  parameter logic [10:0] ID_MFR     = 11'h0A5
)(
  input  logic               tck,
  input  logic               rst,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pins_i,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               out_hiz,
  output logic [BSR_LEN-1:0] cells_o
);
  localparam logic [16:0] ID_CFG = {2'b00, ID_DENSITY, 1'b0, ID_WIDTH, 1'b0, 1'b0,
                                    1'b0, ID_QUAD, 1'b0, ID_BURST4, 1'b0, ID_SEP_IO, 1'b0};
  localparam logic [31:0] ID_VAL = {ID_REV, ID_CFG, ID_MFR, 1'b1};

  tap_st_e st;
  dr_sel_e sel;
  logic    ir_lsb, dr_lsb;

  tap_fsm u_fsm (.clk(tck), .rst(rst), .tms(tms), .st(st));

  scan_ir u_ir (.clk(tck), .rst(rst), .tdi(tdi), .st(st),
                .ir_lsb(ir_lsb), .sel(sel), .hiz(out_hiz));

  scan_dr #(.BSR_LEN(BSR_LEN), .ID_VAL(ID_VAL)) u_dr (
    .clk(tck), .rst(rst), .tdi(tdi), .st(st), .sel(sel),
    .pins_i(pins_i), .dr_lsb(dr_lsb), .cells_o(cells_o));

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= (st == ST_SH_IR) ? ir_lsb : dr_lsb;
      tdo_oe <= (st == ST_SH_IR) || (st == ST_SH_DR);
    end
  end

  AST_OE_ONLY_SHIFT: assert property (@(posedge tck) disable iff (rst)
    tdo_oe |-> (st == ST_SH_DR || st == ST_SH_IR)); // R9
endmodule

// File: tb/sim_scan_port.sv
module sim_scan_port;
  localparam int N = 107;
  localparam logic [31:0] EXP_ID = {3'd0, 2'b00, 3'b001, 1'b0, 2'b11, 1'b0, 1'b0,
                                    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
                                    11'h0A5, 1'b1};

  logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b1;
  logic [N-1:0] pins_i, pat_a, pat_b;
  logic tdo, tdo_oe, out_hiz;
  logic [N-1:0] cells_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic oe_all;

  always #4 tck = ~tck;

  scan_port u0 (.tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .pins_i(pins_i),
                .tdo(tdo), .tdo_oe(tdo_oe), .out_hiz(out_hiz), .cells_o(cells_o));

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic v);
    @(negedge tck); #1; tms = v; @(posedge tck);
  endtask

  task automatic shift(input int n, input logic [127:0] din, output logic [127:0] dout);
    dout = '0; oe_all = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #1;
      dout[i] = tdo; oe_all &= tdo_oe;
      tdi = din[i]; tms = (i == n - 1);
      @(posedge tck);
    end
  endtask

  task automatic finish_scan();
    step(1'b1); step(1'b0); #1;
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
    logic [127:0] o;
    step(1'b1); step(1'b1); step(1'b0); step(1'b0);
    shift(3, {125'd0, op}, o);
    finish_scan();
    cap = o[2:0];
  endtask

  task automatic scan_dr(input int n, input logic [127:0] din, output logic [127:0] dout);
    step(1'b1); step(1'b0); step(1'b0);
    shift(n, din, dout);
    finish_scan();
  endtask

  task automatic t_reset();
    logic [127:0] o;
    chk(tdo_oe == 1'b0, "R1 oe after reset", tdo_oe, 0);
    chk(out_hiz == 1'b0, "R1 hiz after reset", out_hiz, 0);
    step(1'b0);
    scan_dr(32, 128'h0, o);
    chk(o[31:0] == EXP_ID, "R1 R5 id after reset", o[31:0], EXP_ID);
    chk(o[0] == 1'b1, "R5 id bit0", o[0], 1);
  endtask

  task automatic t_bypass();
    logic [2:0] c; logic [127:0] o;
    load_ir(3'b111, c);
    chk(c == 3'b001, "R3 ir capture", c, 3'b001);
    step(1'b1); step(1'b0); step(1'b0);
    #1 chk(tdo_oe == 1'b0, "R9 oe waits for falling edge", tdo_oe, 0);
    shift(8, 128'hB3, o);
    chk(oe_all == 1'b1, "R9 oe in shift", oe_all, 1);
    chk(o[7:0] == {8'hB3 << 1}, "R6 bypass delay", o[7:0], {8'hB3 << 1});
    finish_scan();
    chk(tdo_oe == 1'b0, "R9 oe after shift", tdo_oe, 0);
  endtask

  task automatic t_reserved(input logic [2:0] op);
    logic [2:0] c; logic [127:0] o;
    load_ir(op, c);
    scan_dr(4, 128'hD, o);
    chk(o[3:0] == 4'hA, "R4 reserved opcode bypass", o[3:0], 4'hA);
    chk(out_hiz == 1'b0, "R4 reserved no hiz", out_hiz, 0);
  endtask

  task automatic t_sample();
    logic [2:0] c; logic [127:0] o;
    pins_i = pat_a;
    load_ir(3'b100, c);
    chk(out_hiz == 1'b0, "R4 sample no hiz", out_hiz, 0);
    scan_dr(N, {21'd0, pat_b}, o);
    chk(o[N-1:0] == pat_a, "R7 sample capture", o[N-1:0], pat_a);
    chk(cells_o == pat_b, "R8 sample update", cells_o, pat_b);
  endtask

  task automatic t_extest();
    logic [2:0] c; logic [127:0] o;
    pins_i = pat_b;
    load_ir(3'b000, c);
    chk(out_hiz == 1'b1, "R4 extest hiz", out_hiz, 1);
    scan_dr(N, {21'd0, pat_a}, o);
    chk(o[N-1:0] == pat_b, "R7 extest capture", o[N-1:0], pat_b);
    chk(cells_o == pat_a, "R8 extest update", cells_o, pat_a);
  endtask

  task automatic t_hold_under_bypass();
    logic [2:0] c; logic [127:0] o;
    load_ir(3'b111, c);
    scan_dr(N, {21'd0, pat_b}, o);
    chk(cells_o == pat_a, "R8 cells hold under bypass", cells_o, pat_a);
  endtask

  task automatic t_samplez_and_id();
    logic [2:0] c; logic [127:0] o;
    load_ir(3'b010, c);
    chk(out_hiz == 1'b1, "R4 sample-z hiz", out_hiz, 1);
    load_ir(3'b001, c);
    chk(out_hiz == 1'b0, "R4 idcode no hiz", out_hiz, 0);
    scan_dr(32, 128'h0, o);
    chk(o[31:0] == EXP_ID, "R5 id via load", o[31:0], EXP_ID);
  endtask

  task automatic t_tms_reset();
    logic [2:0] c; logic [127:0] o;
    load_ir(3'b000, c);
    step(1'b1); step(1'b0); step(1'b0); step(1'b0);
    for (int i = 0; i < 5; i++) step(1'b1);
    step(1'b0); #1;
    chk(out_hiz == 1'b0, "R2 tms reset clears hiz", out_hiz, 0);
    scan_dr(32, 128'h0, o);
    chk(o[31:0] == EXP_ID, "R2 tms reset idcode", o[31:0], EXP_ID);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      pat_a[i] = ((i * 7 + 3) % 5) < 2;
      pat_b[i] = ((i * 3 + 1) % 4) != 0;
    end
    pins_i = '0;
    repeat (4) @(posedge tck);
    @(negedge tck); rst = 1'b0;
    @(posedge tck); #1;
    t_reset();
    t_bypass();
    t_reserved(3'b011);
    t_reserved(3'b101);
    t_reserved(3'b110);
    t_sample();
    t_extest();
    t_hold_under_bypass();
    t_samplez_and_id();
    t_tms_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1-chain hung actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule